// File: doc/BRIEF.md
# Interleaved SRAM Slot Arbiter

This block owns a single 32-bit-wide SRAM that is clocked at twice the rate at which video words arrive. The memory cycles alternate strictly between two users. Even cycles belong to a video capture port that writes full words. Odd cycles belong to a microcontroller port that reads or writes single bytes. Because the split is fixed, the capture stream always gets half of the memory bandwidth, whatever the microcontroller does. The microcontroller gets the other half at a fixed latency.

The microcontroller presents a 16-bit byte address on its external memory bus. A bank register, written through its own strobe, supplies the upper word-address bits, so the processor can reach a frame far larger than 64K bytes. The memory is split into two pages. Capture writes into one page while the processor sees the other. A flip strobe exchanges the two pages, so a finished frame can be frozen for inspection while capture continues into the page the processor has released.

Every SRAM word address is built as {page bit, bank bits, word offset}. The processor's two low address bits pick the byte lane. A read returns its byte, together with a one-cycle ready pulse, in the cycle after its memory slot.

Top module: `sramSlotArbiter`

## Requirements
- R1: After reset the first cycle is a capture slot (capSlot high). The SRAM is idle (sramWe and sramOe low), cpuReady is low, the bank register is 0 and the capture page is 0.
- R2: The slots alternate every clock. capSlot is high in capture slots and low in processor slots.
- R3: In a capture slot with capValid high, the block drives a full-word write: sramWe=1, sramBe=4'b1111, sramWdata=capData and sramAddr={capture page, capAddr}.
- R4: capValid has no effect in a processor slot. In a capture slot with capValid low, sramWe, sramOe, sramBe, sramAddr and sramWdata are all 0.
- R5: A request registered by cpuReq is served in the first processor slot after the edge that registers it. The SRAM never sees a processor access in a capture slot, and a processor slot with nothing pending leaves the SRAM idle (all outputs 0).
- R6: A processor write enables only byte lane cpuAddr[1:0] (lane n is bits 8n+7:8n, sramBe bit n). It puts cpuWdata on every lane of sramWdata. The other lanes of the memory word keep their contents.
- R7: A processor read drives sramOe=1 with sramWe=0 and sramBe=0. In the next cycle cpuReady pulses for one cycle and cpuRdata carries lane cpuAddr[1:0] of the word read; cpuRdata holds until the next read. A write also pulses cpuReady in the cycle after its slot. sramWe and sramOe are never high together.
- R8: The processor word address is {~capture page, bank register, cpuAddr[15:2]}. bankWe loads bankData into the bank register. The bank and page values are taken in the cycle of cpuReq.
- R9: A pageFlip pulse toggles the capture page. The processor always addresses the opposite page, so after a flip the processor sees the words that capture wrote before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capValid | input | 1 | Capture word present this cycle |
| capAddr | input | 17 | Capture word address within the page {bank, offset} |
| capData | input | 32 | Capture word |
| pageFlip | input | 1 | Pulse that swaps the capture and processor pages |
| cpuReq | input | 1 | Processor access request, one-cycle pulse |
| cpuWe | input | 1 | 1 = byte write, 0 = byte read |
| cpuAddr | input | 16 | Processor byte address |
| cpuWdata | input | 8 | Processor write byte |
| bankWe | input | 1 | Load the bank register |
| bankData | input | 3 | New bank value |
| cpuRdata | output | 8 | Byte returned by the last read |
| cpuReady | output | 1 | Access completed pulse |
| capSlot | output | 1 | High during capture slots |
| sramAddr | output | 18 | SRAM word address |
| sramWdata | output | 32 | SRAM write data |
| sramRdata | input | 32 | SRAM read data, valid in the cycle sramOe is high |
| sramBe | output | 4 | Byte-lane write enables |
| sramWe | output | 1 | SRAM write enable |
| sramOe | output | 1 | SRAM output enable |

## Verification
The assertions assume that the processor keeps at most one access outstanding and raises no new cpuReq until it has seen cpuReady. They also assume that sramRdata is valid while sramOe is high. The stimulus meets these assumptions: each processor task waits for the ready pulse before it returns, and the bench memory model drives its read word straight from the address. The capture source is allowed to assert capValid in either phase, including in a long run next to processor traffic. This lets the assertions check that only the even-cycle words reach the memory.

// File: rtl/sramArbPkg.sv
package sramArbPkg;
  // strobes from the slot controller to the datapath
  typedef struct packed {
    logic latchReq;  // register the processor request this cycle
    logic capWr;     // full-word capture write in this slot
    logic cpuWr;     // byte write in this slot
    logic cpuRd;     // word read in this slot
  } slotStrobe_t;
endpackage

// File: rtl/slotArbCtrl.sv
module slotArbCtrl
  import sramArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        capValid,
  input  logic        cpuReq,
  input  logic        cpuWe,
  output slotStrobe_t strobe,
  output logic        capSlot,
  output logic        cpuReady
);
  logic oddPhase;
  logic pendValid;
  logic pendWe;
  logic cpuGo;

  assign capSlot = ~oddPhase;
  assign cpuGo   = oddPhase & pendValid;

  always_comb begin
    strobe.capWr    = ~oddPhase & capValid;
    strobe.cpuWr    = cpuGo & pendWe;
    strobe.cpuRd    = cpuGo & ~pendWe;
    strobe.latchReq = cpuReq & (~pendValid | cpuGo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oddPhase  <= 1'b0;
      pendValid <= 1'b0;
      pendWe    <= 1'b0;
      cpuReady  <= 1'b0;
    end else begin
      oddPhase <= ~oddPhase;
      cpuReady <= cpuGo;
      if (strobe.latchReq) begin
        pendValid <= 1'b1;
        pendWe    <= cpuWe;
      end else if (cpuGo) begin
        pendValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slotArbDatapath.sv
module slotArbDatapath
  import sramArbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CPU_AW = 16,
  parameter int BANK_W = 3,
  localparam int LANES   = DATA_W / BYTE_W,
  localparam int LANE_W  = $clog2(LANES),
  localparam int OFF_W   = CPU_AW - LANE_W,
  localparam int CAP_AW  = BANK_W + OFF_W,
  localparam int SRAM_AW = CAP_AW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrobe_t        strobe,
  input  logic [CAP_AW-1:0]  capAddr,
  input  logic [DATA_W-1:0]  capData,
  input  logic               pageFlip,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0]  cpuWdata,
  input  logic               bankWe,
  input  logic [BANK_W-1:0]  bankData,
  input  logic [DATA_W-1:0]  sramRdata,
  output logic [BYTE_W-1:0]  cpuRdata,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DATA_W-1:0]  sramWdata,
  output logic [LANES-1:0]   sramBe,
  output logic               sramWe,
  output logic               sramOe
);
  logic [BANK_W-1:0]  bankReg;
  logic               capPage;
  logic [SRAM_AW-1:0] pendAddr;
  logic [LANE_W-1:0]  pendLane;
  logic [BYTE_W-1:0]  pendByte;
  logic [BYTE_W-1:0]  rdLane [LANES];
  logic [DATA_W-1:0]  repByte;
  logic [LANES-1:0]   laneHot;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdLane[g]                    = sramRdata[g*BYTE_W +: BYTE_W];
    assign repByte[g*BYTE_W +: BYTE_W]  = pendByte;
    assign laneHot[g]                   = (pendLane == LANE_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg  <= '0;
      capPage  <= 1'b0;
      pendAddr <= '0;
      pendLane <= '0;
      pendByte <= '0;
      cpuRdata <= '0;
    end else begin
      if (bankWe)   bankReg <= bankData;
      if (pageFlip) capPage <= ~capPage;
      if (strobe.latchReq) begin
        pendAddr <= {~capPage, bankReg, cpuAddr[CPU_AW-1:LANE_W]};
        pendLane <= cpuAddr[LANE_W-1:0];
        pendByte <= cpuWdata;
      end
      if (strobe.cpuRd) cpuRdata <= rdLane[pendLane];
    end
  end

  always_comb begin
    sramAddr  = '0;
    sramWdata = '0;
    sramBe    = '0;
    sramWe    = 1'b0;
    sramOe    = 1'b0;
    if (strobe.capWr) begin
      sramAddr  = {capPage, capAddr};
      sramWdata = capData;
      sramBe    = '1;
      sramWe    = 1'b1;
    end else if (strobe.cpuWr) begin
      sramAddr  = pendAddr;
      sramWdata = repByte;
      sramBe    = laneHot;
      sramWe    = 1'b1;
    end else if (strobe.cpuRd) begin
      sramAddr  = pendAddr;
      sramOe    = 1'b1;
    end
  end
endmodule

// File: rtl/sramSlotArbiter.sv
module sramSlotArbiter
  import sramArbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CPU_AW = 16,
  parameter int BANK_W = 3,
  localparam int LANES   = DATA_W / BYTE_W,
  localparam int LANE_W  = $clog2(LANES),
  localparam int CAP_AW  = BANK_W + CPU_AW - LANE_W,
  localparam int SRAM_AW = CAP_AW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capValid,
  input  logic [CAP_AW-1:0]  capAddr,
  input  logic [DATA_W-1:0]  capData,
  input  logic               pageFlip,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0]  cpuWdata,
  input  logic               bankWe,
  input  logic [BANK_W-1:0]  bankData,
  output logic [BYTE_W-1:0]  cpuRdata,
  output logic               cpuReady,
  output logic               capSlot,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DATA_W-1:0]  sramWdata,
  input  logic [DATA_W-1:0]  sramRdata,
  output logic [LANES-1:0]   sramBe,
  output logic               sramWe,
  output logic               sramOe
);
  slotStrobe_t strobe;

  slotArbCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .capValid (capValid),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .strobe   (strobe),
    .capSlot  (capSlot),
    .cpuReady (cpuReady)
  );

  slotArbDatapath #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .CPU_AW (CPU_AW),
    .BANK_W (BANK_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .capAddr   (capAddr),
    .capData   (capData),
    .pageFlip  (pageFlip),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .bankWe    (bankWe),
    .bankData  (bankData),
    .sramRdata (sramRdata),
    .cpuRdata  (cpuRdata),
    .sramAddr  (sramAddr),
    .sramWdata (sramWdata),
    .sramBe    (sramBe),
    .sramWe    (sramWe),
    .sramOe    (sramOe)
  );
endmodule

// File: rtl/sramSlotArbiterChk.sv
module sramSlotArbiterChk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              capSlot,
  input logic              capValid,
  input logic [DATA_W-1:0] capData,
  input logic [DATA_W-1:0] sramWdata,
  input logic [LANES-1:0]  sramBe,
  input logic              sramWe,
  input logic              sramOe,
  input logic              cpuReady
);
  AST_SLOT_ALT: assert property (@(posedge clk) disable iff (!rstN)
    capSlot |=> !capSlot); // R2
  AST_SLOT_BACK: assert property (@(posedge clk) disable iff (!rstN)
    !capSlot |=> capSlot); // R2
  AST_CAP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (capSlot && capValid) |-> (sramWe && sramBe == {LANES{1'b1}} && sramWdata == capData)); // R3
  AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (capSlot && !capValid) |-> (!sramWe && !sramOe)); // R4
  AST_ODD_NO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    !capSlot |-> ($countones(sramBe) <= 1)); // R4
  AST_NO_READ_IN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    capSlot |-> !sramOe); // R5
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (!capSlot && sramWe) |-> ($countones(sramBe) == 1)); // R6
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sramWe && sramOe)); // R7
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    (!capSlot && (sramWe || sramOe)) |=> cpuReady); // R7
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> $past(!capSlot && (sramWe || sramOe))); // R7
endmodule

bind sramSlotArbiter sramSlotArbiterChk #(.DATA_W(DATA_W), .LANES(LANES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .capSlot   (capSlot),
  .capValid  (capValid),
  .capData   (capData),
  .sramWdata (sramWdata),
  .sramBe    (sramBe),
  .sramWe    (sramWe),
  .sramOe    (sramOe),
  .cpuReady  (cpuReady)
);

// File: tb/sramSlotArbiter_test.sv
`timescale 1ns/1ps
module sramSlotArbiter_test;
  localparam int CAP_AW  = 17;
  localparam int SRAM_AW = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capValid = 1'b0;
  logic [CAP_AW-1:0] capAddr = '0;
  logic [31:0] capData = '0;
  logic        pageFlip = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic        bankWe = 1'b0;
  logic [2:0]  bankData = '0;
  logic [7:0]  cpuRdata;
  logic        cpuReady;
  logic        capSlot;
  logic [SRAM_AW-1:0] sramAddr;
  logic [31:0] sramWdata;
  logic [31:0] sramRdata;
  logic [3:0]  sramBe;
  logic        sramWe;
  logic        sramOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sramSlotArbiter uut (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capAddr(capAddr), .capData(capData),
    .pageFlip(pageFlip), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .bankWe(bankWe), .bankData(bankData), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .capSlot(capSlot), .sramAddr(sramAddr), .sramWdata(sramWdata),
    .sramRdata(sramRdata), .sramBe(sramBe), .sramWe(sramWe), .sramOe(sramOe)
  );

  // behavioural SRAM
  logic [31:0] mem [logic [SRAM_AW-1:0]];
  int memEpoch = 0;

  function automatic logic [31:0] memRead(input logic [SRAM_AW-1:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(sramAddr or sramOe or memEpoch)
    sramRdata = sramOe ? memRead(sramAddr) : 32'h0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  // reference model: slot parity, one pending access, bank and page state
  int          mPhase;
  bit          mPendValid, mPendWe, mCapPage, mReady;
  logic [SRAM_AW-1:0] mPendAddr;
  int          mPendLane;
  logic [7:0]  mPendByte, mRdata;
  logic [2:0]  mBank;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mPendValid = 0; mPendWe = 0; mCapPage = 0; mReady = 0;
      mPendAddr = '0; mPendLane = 0; mPendByte = '0; mRdata = '0; mBank = '0;
    end else begin
      bit serve;
      logic [31:0] w;
      serve = (mPhase == 1) && mPendValid;
      if (serve && !mPendWe) begin
        w = memRead(mPendAddr);
        mRdata = w[mPendLane*8 +: 8];
      end
      if (cpuReq && (!mPendValid || serve)) begin
        mPendValid = 1; mPendWe = cpuWe;
        mPendAddr = {~mCapPage, mBank, cpuAddr[15:2]};
        mPendLane = int'(cpuAddr[1:0]);
        mPendByte = cpuWdata;
      end else if (serve) begin
        mPendValid = 0;
      end
      if (bankWe) mBank = bankData;
      if (pageFlip) mCapPage = ~mCapPage;
      mReady = serve;
      mPhase = 1 - mPhase;
    end
  end

  // per-cycle comparison at mid-cycle, then memory update
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic expWe, expOe;
      logic [3:0] expBe;
      logic [SRAM_AW-1:0] expAddr;
      logic [31:0] expWd;
      string tag;
      expWe = 0; expOe = 0; expBe = 0; expAddr = '0; expWd = '0;
      if (mPhase == 0) begin
        tag = capValid ? "R3" : "R4";
        if (capValid) begin
          expWe = 1; expBe = 4'hF; expAddr = {mCapPage, capAddr}; expWd = capData;
        end
      end else if (mPendValid) begin
        tag = mPendWe ? "R6" : "R7";
        expAddr = mPendAddr;
        if (mPendWe) begin
          expWe = 1; expBe = 4'b0001 << mPendLane; expWd = {4{mPendByte}};
        end else begin
          expOe = 1;
        end
      end else begin
        tag = capValid ? "R4" : "R5";
      end
      check("R2", capSlot, mPhase == 0, "capSlot");
      check(tag, {sramWe, sramOe, sramBe}, {expWe, expOe, expBe}, "we/oe/be");
      check((mPhase == 1 && mPendValid) ? "R8" : tag, sramAddr, expAddr, "sramAddr");
      check(tag, sramWdata, expWd, "sramWdata");
      check("R7", {cpuReady, cpuRdata}, {mReady, mRdata}, "ready/rdata");
    end
    if (sramWe) begin
      logic [31:0] w;
      w = memRead(sramAddr);
      for (int l = 0; l < 4; l++)
        if (sramBe[l]) w[l*8 +: 8] = sramWdata[l*8 +: 8];
      mem[sramAddr] = w;
      memEpoch++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic capWord(input logic [CAP_AW-1:0] a, input logic [31:0] d, input bit inCapSlot);
    while (capSlot != inCapSlot) tick();
    capValid = 1; capAddr = a; capData = d;
    tick();
    capValid = 0; capAddr = '0; capData = '0;
  endtask

  task automatic setBank(input logic [2:0] b);
    bankWe = 1; bankData = b;
    tick();
    bankWe = 0; bankData = '0;
  endtask

  task automatic cpuOp(input bit we, input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] got);
    bit startCap;
    int waited;
    startCap = capSlot;
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = we ? d : 8'h0;
    tick();
    cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuWdata = '0;
    waited = 0;
    got = 8'h0;
    while (waited < 8) begin
      @(negedge clk);
      waited++;
      if (cpuReady) begin
        got = cpuRdata;
        break;
      end
    end
    // R5: served in the first odd slot, ready in the cycle after it
    check("R5", waited, startCap ? 2 : 3, "ready latency");
    tick();
  endtask

  task automatic readExpect(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    cpuOp(0, a, 8'h0, got);
    check(tag, got, exp, "read byte");
  endtask

  task automatic writeByte(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] got;
    cpuOp(1, a, d, got);
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", {capSlot, sramWe, sramOe, cpuReady}, 4'b1000, "post-reset state");
    check("R1", sramAddr, 0, "post-reset addr");
    tick();

    // capture: two words in even slots, one in an odd slot (R3, R4)
    capWord(17'd5, 32'hA1B2C3D4, 1);
    capWord(17'd9, 32'hFFFFFFFF, 0);
    capWord({3'd2, 14'd7}, 32'h11223344, 1);

    // processor on page 1, bank 0 (R6, R7)
    writeByte(16'h0011, 8'h5A);
    readExpect(16'h0011, 8'h5A, "R7");
    writeByte(16'h0013, 8'h77);
    readExpect(16'h0011, 8'h5A, "R6");
    readExpect(16'h0013, 8'h77, "R6");
    readExpect(16'h0010, 8'h00, "R6");

    // bank separation (R8)
    setBank(3'd2);
    writeByte(16'h0011, 8'h99);
    readExpect(16'h0011, 8'h99, "R8");
    setBank(3'd0);
    readExpect(16'h0011, 8'h5A, "R8");

    // page flip: processor now sees the captured page (R9)
    pageFlip = 1; tick(); pageFlip = 0;
    readExpect(16'h0014, 8'hD4, "R9");
    readExpect(16'h0016, 8'hB2, "R9");
    readExpect(16'h0024, 8'h00, "R4");
    readExpect(16'h0011, 8'h00, "R9");
    setBank(3'd2);
    readExpect(16'h001F, 8'h11, "R8");

    // capture stream running on every cycle next to processor traffic
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          capValid = 1; capAddr = 17'(300 + i); capData = 32'hC0DE0000 + i;
          tick();
        end
        capValid = 0; capAddr = '0; capData = '0;
      end
      begin
        setBank(3'd0);
        writeByte(16'h0101, 8'h3C);
        readExpect(16'h0101, 8'h3C, "R5");
        readExpect(16'h0016, 8'hB2, "R5");
      end
    join

    // flip back: capture stream went to page 1, processor sees it now
    pageFlip = 1; tick(); pageFlip = 0;
    readExpect(16'h0101, 8'h00, "R9");
    readExpect(16'h0011, 8'h5A, "R9");
    repeat (4) tick();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule